// File: doc/BRIEF.md
# SIMD Lane Mode-Mask Controller

This block keeps the enable state of every lane in an array that runs one broadcast instruction at a time. Each lane holds two mask bits, one for its lower 32-bit half and one for its upper half. In 64-bit work the pair acts as one bit, and in 32-bit work the two halves behave as separate lanes. The control unit updates the mask with a 3-bit command. It can load a vector of enables, copy the lanes' own compare results, complement every bit, turn every bit on, or AND the mask with the compare results.

The mask goes out as per-half enables and as a combined 64-bit enable for each lane. It also gates the register write-back strobes, so a lane that is off does not commit results. Data routing between lanes is never masked: every lane takes part in a routing transfer. An if/else without branches uses three commands: set from the test, run the "then" part, complement, run the "else" part, then set all on.

Top module: `mmask_ctrl`

## Requirements
- R1: After reset every lower and upper mask bit of every lane is 1.
- R2: Opcode 000 and the unused opcodes 110 and 111 leave every mask bit unchanged.
- R3: Opcode 001 loads the mask from the command vector. With `cmd_wide`=1, both halves of lane i take `vec_lo[i]`. With `cmd_wide`=0, the lower half takes `vec_lo[i]` and the upper half takes `vec_hi[i]`.
- R4: Opcode 010 loads the mask from the compare inputs. The half selection is the same as in R3, using `cmp_lo` and `cmp_hi`.
- R5: Opcode 011 inverts every mask bit of both halves, whatever the value of `cmd_wide`.
- R6: Opcode 100 sets every mask bit to 1.
- R7: Opcode 101 ANDs each mask bit with its compare bit. The half selection is the same as in R4 (wide: both halves with `cmp_lo[i]`).
- R8: A command changes the mask outputs only after the next rising clock edge. During the command cycle the outputs still show the old mask.
- R9: `en_wide[i]` is 1 exactly when both halves of lane i are enabled.
- R10: With `wb_valid`=0 no write strobe is set. With `wb_valid`=1 and `wb_wide`=1, both strobes of lane i equal `en_wide[i]`. With `wb_valid`=1 and `wb_wide`=0, each half's strobe equals that half's enable.
- R11: `route_we` is set in every lane whenever `route_valid` is 1, including lanes whose mask is 0. It is 0 in every lane when `route_valid` is 0.
- R12: The sequence set-from-compare, complement, all-on first enables exactly the lanes whose compare is true, then exactly the other lanes, and finally every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Mask update opcode |
| cmd_wide | input | 1 | 1: 64-bit command, both halves written together |
| vec_lo | input | LANES | Control vector, lower halves (or whole lane) |
| vec_hi | input | LANES | Control vector, upper halves |
| cmp_lo | input | LANES | Per-lane compare result, lower half (or whole lane) |
| cmp_hi | input | LANES | Per-lane compare result, upper half |
| wb_valid | input | 1 | Broadcast write-back request |
| wb_wide | input | 1 | Write-back is 64-bit |
| route_valid | input | 1 | Inter-lane routing transfer active |
| en_lo | output | LANES | Lower-half execute enable |
| en_hi | output | LANES | Upper-half execute enable |
| en_wide | output | LANES | 64-bit execute enable |
| wb_we_lo | output | LANES | Lower-half write strobe |
| wb_we_hi | output | LANES | Upper-half write strobe |
| route_we | output | LANES | Routing receive strobe |

## Verification
The bench checks mask loads in both widths. A design that ignored `cmd_wide` would give the upper halves `vec_hi` in a 64-bit load. A design that swapped vectors would mix up the two halves. Complement is applied to a mask whose halves differ, so an inversion that only acts on 64-bit lanes or only on the lower half shows up at once. The mask outputs are sampled during the command cycle itself, which catches an update that bypasses the register. A mixed-width write-back with unequal halves exposes gating that uses the wrong enable. A routing transfer with the mask cleared to zero exposes routing that is wrongly masked.

// File: rtl/mmask_pkg.sv
package mmask_pkg;

  typedef enum logic [2:0] {
    MM_HOLD  = 3'b000,
    MM_LOAD  = 3'b001,
    MM_TEST  = 3'b010,
    MM_FLIP  = 3'b011,
    MM_ALLON = 3'b100,
    MM_ANDT  = 3'b101
  } mm_op_e;

  typedef struct packed {
    logic load;
    logic test;
    logic flip;
    logic allon;
    logic andt;
  } mm_ctl_t;

  // Next value of one lane's {hi, lo} mask pair.
  function automatic logic [1:0] mm_next(mm_ctl_t c, logic wide, logic [1:0] cur,
                                         logic [1:0] vec, logic [1:0] cmp);
    logic [1:0] sv;
    logic [1:0] sc;
    sv = wide ? {2{vec[0]}} : vec;
    sc = wide ? {2{cmp[0]}} : cmp;
    if (c.load)       return sv;
    else if (c.test)  return sc;
    else if (c.flip)  return ~cur;
    else if (c.allon) return 2'b11;
    else if (c.andt)  return cur & sc;
    else              return cur;
  endfunction

  // Write strobes {hi, lo} of one lane.
  function automatic logic [1:0] mm_gate(logic valid, logic wide, logic lo, logic hi);
    if (!valid)    return 2'b00;
    else if (wide) return {2{lo & hi}};
    else           return {hi, lo};
  endfunction

endpackage

// File: rtl/mmask_decode.sv
module mmask_decode
  import mmask_pkg::*;
(
  input  logic [2:0] op,
  output mm_ctl_t    ctl,
  output logic       upd
);
  always_comb begin
    ctl = '0;
    case (op)
      MM_LOAD:  ctl.load  = 1'b1;
      MM_TEST:  ctl.test  = 1'b1;
      MM_FLIP:  ctl.flip  = 1'b1;
      MM_ALLON: ctl.allon = 1'b1;
      MM_ANDT:  ctl.andt  = 1'b1;
      default:  ctl = '0;
    endcase
  end

  assign upd = |ctl;
endmodule

// File: rtl/mmask_lane.sv
module mmask_lane
  import mmask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  mm_ctl_t    ctl,
  input  logic       wide,
  input  logic [1:0] vec,
  input  logic [1:0] cmp,
  output logic [1:0] bits
);
  always_ff @(posedge clk) begin
    if (!rst_n)   bits <= 2'b11;
    else if (upd) bits <= mm_next(ctl, wide, bits, vec, cmp);
  end
endmodule

// File: rtl/mmask_gate.sv
module mmask_gate
  import mmask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [LANES-1:0] lo,
  input  logic [LANES-1:0] hi,
  input  logic             wb_valid,
  input  logic             wb_wide,
  input  logic             route_valid,
  output logic [LANES-1:0] en_wide,
  output logic [LANES-1:0] we_lo,
  output logic [LANES-1:0] we_hi,
  output logic [LANES-1:0] route_we
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0] we;
    assign we          = mm_gate(wb_valid, wb_wide, lo[g], hi[g]);
    assign we_lo[g]    = we[0];
    assign we_hi[g]    = we[1];
    assign en_wide[g]  = lo[g] & hi[g];
    assign route_we[g] = route_valid;
  end
endmodule

// File: rtl/mmask_ctrl.sv
module mmask_ctrl
  import mmask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wide,
  input  logic [LANES-1:0] vec_lo,
  input  logic [LANES-1:0] vec_hi,
  input  logic [LANES-1:0] cmp_lo,
  input  logic [LANES-1:0] cmp_hi,
  input  logic             wb_valid,
  input  logic             wb_wide,
  input  logic             route_valid,
  output logic [LANES-1:0] en_lo,
  output logic [LANES-1:0] en_hi,
  output logic [LANES-1:0] en_wide,
  output logic [LANES-1:0] wb_we_lo,
  output logic [LANES-1:0] wb_we_hi,
  output logic [LANES-1:0] route_we
);
  mm_ctl_t ctl;
  logic    mask_upd;

  mmask_decode u_dec (.op(cmd_op), .ctl(ctl), .upd(mask_upd));

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    logic [1:0] pair;
    mmask_lane u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (mask_upd),
      .ctl  (ctl),
      .wide (cmd_wide),
      .vec  ({vec_hi[g], vec_lo[g]}),
      .cmp  ({cmp_hi[g], cmp_lo[g]}),
      .bits (pair)
    );
    assign en_lo[g] = pair[0];
    assign en_hi[g] = pair[1];
  end

  mmask_gate #(.LANES(LANES)) u_gate (
    .lo         (en_lo),
    .hi         (en_hi),
    .wb_valid   (wb_valid),
    .wb_wide    (wb_wide),
    .route_valid(route_valid),
    .en_wide    (en_wide),
    .we_lo      (wb_we_lo),
    .we_hi      (wb_we_hi),
    .route_we   (route_we)
  );
endmodule

// File: rtl/mmask_chk.sv
module mmask_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_op,
  input logic             cmd_wide,
  input logic             wb_valid,
  input logic [LANES-1:0] en_lo,
  input logic [LANES-1:0] en_hi,
  input logic [LANES-1:0] wb_we_lo,
  input logic [LANES-1:0] wb_we_hi,
  input logic             route_valid,
  input logic [LANES-1:0] route_we
);
  // R1
  reset_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&en_lo && &en_hi));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'b000 || cmd_op == 3'b110 || cmd_op == 3'b111)
      |=> ($stable(en_lo) && $stable(en_hi)));

  // R3
  wide_load_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'b001 && cmd_wide) |=> (en_lo == en_hi));

  // R5
  flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'b011) |=> (en_lo == ~$past(en_lo) && en_hi == ~$past(en_hi)));

  // R6
  allon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'b100) |=> (&en_lo && &en_hi));

  // R7
  and_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'b101) |=> ((en_lo & ~$past(en_lo)) == '0 && (en_hi & ~$past(en_hi)) == '0));

  // R10
  wb_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wb_we_lo & ~en_lo) == '0 && (wb_we_hi & ~en_hi) == '0));

  // R10
  wb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (wb_we_lo == '0 && wb_we_hi == '0));

  // R11
  route_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> (&route_we));
endmodule

bind mmask_ctrl mmask_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_wide(cmd_wide),
  .wb_valid(wb_valid), .en_lo(en_lo), .en_hi(en_hi),
  .wb_we_lo(wb_we_lo), .wb_we_hi(wb_we_hi),
  .route_valid(route_valid), .route_we(route_we)
);

// File: tb/test_mmask_ctrl.sv
module test_mmask_ctrl;
  localparam int L = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cmd_op = 3'b000;
  logic         cmd_wide = 1'b0;
  logic [L-1:0] vec_lo = '0, vec_hi = '0, cmp_lo = '0, cmp_hi = '0;
  logic         wb_valid = 1'b0, wb_wide = 1'b0, route_valid = 1'b0;
  logic [L-1:0] en_lo, en_hi, en_wide, wb_we_lo, wb_we_hi, route_we;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmask_ctrl #(.LANES(L)) i_mmask_ctrl (.*);

  typedef struct {
    logic [L-1:0] lo;
    logic [L-1:0] hi;
    string        req;
  } item_t;
  item_t sb[$];

  logic [L-1:0] m_lo, m_hi;

  task automatic check(bit ok, string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] rnd_vec();
    logic [L-1:0] v;
    for (int i = 0; i < L; i++) v[i] = 1'($urandom % 2);
    return v;
  endfunction

  // Monitor: compares registered mask outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(en_lo === it.lo, it.req, en_lo, it.lo);
        check(en_hi === it.hi, it.req, en_hi, it.hi);
        // R9: combined enable needs both halves
        check(en_wide === (it.lo & it.hi), "R9", en_wide, it.lo & it.hi);
      end
    end
  end

  // Driver: one command; model updated per lane, result queued
  task automatic do_cmd(logic [2:0] op, logic wide, logic [L-1:0] vl, logic [L-1:0] vh,
                        logic [L-1:0] cl, logic [L-1:0] ch, string req);
    @(negedge clk);
    cmd_op = op; cmd_wide = wide;
    vec_lo = vl; vec_hi = vh; cmp_lo = cl; cmp_hi = ch;
    #1;
    // R8: old mask still visible during the command cycle
    check(en_lo === m_lo && en_hi === m_hi, "R8", en_lo, m_lo);
    @(posedge clk);
    for (int i = 0; i < L; i++) begin
      case (op)
        3'b001: begin m_lo[i] = vl[i]; m_hi[i] = wide ? vl[i] : vh[i]; end
        3'b010: begin m_lo[i] = cl[i]; m_hi[i] = wide ? cl[i] : ch[i]; end
        3'b011: begin m_lo[i] = !m_lo[i]; m_hi[i] = !m_hi[i]; end
        3'b100: begin m_lo[i] = 1'b1; m_hi[i] = 1'b1; end
        3'b101: begin m_lo[i] = m_lo[i] && cl[i]; m_hi[i] = m_hi[i] && (wide ? cl[i] : ch[i]); end
        default: ;
      endcase
    end
    sb.push_back('{m_lo, m_hi, req});
  endtask

  task automatic check_gate(logic v, logic w, logic rv, string req);
    logic [L-1:0] xl, xh, xr;
    @(negedge clk);
    cmd_op = 3'b000;
    wb_valid = v; wb_wide = w; route_valid = rv;
    #1;
    for (int i = 0; i < L; i++) begin
      xl[i] = v && (w ? (m_lo[i] && m_hi[i]) : m_lo[i]);
      xh[i] = v && (w ? (m_lo[i] && m_hi[i]) : m_hi[i]);
      xr[i] = rv;
    end
    check(wb_we_lo === xl, req, wb_we_lo, xl);
    check(wb_we_hi === xh, req, wb_we_hi, xh);
    check(route_we === xr, "R11", route_we, xr);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] a, b, c, d;
    m_lo = '1; m_hi = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(en_lo === '1 && en_hi === '1, "R1", en_lo & en_hi, '1);

    a = rnd_vec(); b = rnd_vec();
    do_cmd(3'b001, 1'b1, a, b, '0, '0, "R3 wide load");
    do_cmd(3'b001, 1'b0, a, b, '0, '0, "R3 half load");
    do_cmd(3'b011, 1'b1, '0, '0, '0, '0, "R5 flip wide flag");
    do_cmd(3'b011, 1'b0, '0, '0, '0, '0, "R5 flip half flag");
    // R2: hold and unused codes
    do_cmd(3'b000, 1'b0, ~a, ~b, a, b, "R2 hold");
    do_cmd(3'b110, 1'b0, ~a, ~b, a, b, "R2 code 110");
    do_cmd(3'b111, 1'b1, ~a, ~b, a, b, "R2 code 111");

    c = rnd_vec(); d = rnd_vec();
    do_cmd(3'b010, 1'b1, '0, '0, c, d, "R4 wide test");
    do_cmd(3'b010, 1'b0, '0, '0, c, d, "R4 half test");
    do_cmd(3'b100, 1'b0, '0, '0, '0, '0, "R6 all on");
    do_cmd(3'b101, 1'b0, '0, '0, c, d, "R7 half and");
    do_cmd(3'b101, 1'b1, '0, '0, d, c, "R7 wide and");

    // R10: gating with unequal halves
    do_cmd(3'b001, 1'b0, a, b, '0, '0, "R3 reload");
    check_gate(1'b1, 1'b0, 1'b0, "R10 half wb");
    check_gate(1'b1, 1'b1, 1'b0, "R10 wide wb");
    check_gate(1'b0, 1'b1, 1'b0, "R10 idle wb");

    // R11: routing with every lane masked off
    do_cmd(3'b001, 1'b1, '0, '0, '0, '0, "R3 clear");
    check_gate(1'b0, 1'b0, 1'b1, "R10 off");
    check_gate(1'b1, 1'b1, 1'b1, "R10 off wide");

    // R12: if/else sequence
    c = rnd_vec();
    do_cmd(3'b010, 1'b1, '0, '0, c, '0, "R12 then");
    do_cmd(3'b011, 1'b1, '0, '0, '0, '0, "R12 else");
    do_cmd(3'b100, 1'b1, '0, '0, '0, '0, "R12 join");

    @(negedge clk);
    cmd_op = 3'b000; wb_valid = 1'b0; route_valid = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule